// File: doc/BRIEF.md
# Integer-to-Float Normalizing Shifter

This block turns a 27-bit unsigned integer into a 16-bit compact floating-point word. The word has a 4-bit exponent E and a 12-bit mantissa. The mantissa is a 12-bit window of the input, and its lowest bit sits at bit position E. Small values keep full integer precision. Each step up in exponent halves the precision. Values from 4096 to 8191 are stored to the nearest lower even integer, values from 8192 to 16383 to the nearest lower multiple of four, and so on up the range.

The leading one is found without a priority encoder. Four conditional left-shift stages run in a chain, shifting by 8, 4, 2 and 1 bits. Each stage looks only at the top bits of the word the stage before it produced. If those bits are all zero, the stage shifts. The four shift decisions, inverted, form the exponent directly. After the last stage, the mantissa is the top 12 bits of the shifted word.

A parameter chooses between two builds. One is a purely combinational path. The other is a four-stage pipeline with one register per stage. In both builds the valid strobe travels with the data.

Top module: `int2fp_norm`

## Requirements
- R1: The output word places the exponent E in bits [15:12] and the mantissa in bits [11:0], and the mantissa equals input bits [E+11:E].
- R2: An input below 4096, including zero, produces E = 0 and a mantissa equal to the input.
- R3: An input whose highest set bit is at position p, with 11 <= p <= 26, produces E = p - 11. For every nonzero E, mantissa bit 11 is 1.
- R4: An input with bit 26 set produces E = 15 and a mantissa equal to input bits [26:15].
- R5: With PIPELINE = 1, out_valid is high exactly 4 clock cycles after each cycle in which in_valid was high. Inputs accepted on consecutive cycles come out on consecutive cycles, each with its own result.
- R6: With PIPELINE = 0, out_valid and out_data follow in_valid and in_data in the same cycle, with no clock edge in between.
- R7: An active-high synchronous reset discards every input still in the pipeline, so out_valid is low in the cycle after reset and stays low until a new input has crossed all four stages.
- R8: A cycle with in_valid low produces no output: out_valid is low in the matching output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 27 | Unsigned integer to convert |
| out_valid | output | 1 | Output word is valid this cycle |
| out_data | output | 16 | Exponent [15:12], mantissa [11:0] |

## Verification
In the pipelined build, a new input can be accepted in the same cycle that an older result leaves the last stage. Back-to-back bursts with gaps of varied length provoke this. A reference model with four slots checks every output cycle, so a result that is dropped, doubled or from the wrong slot shows up at once. Reset can also fall on a cycle when valid inputs are in flight and a fresh input is being presented. The bench asserts reset in the middle of a burst and checks that none of those inputs ever comes out.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;

  // Left-shift amount used by stage k (stage 0 shifts the most).
  function automatic int stage_shift(input int exp_w, input int k);
    return 1 << (exp_w - 1 - k);
  endfunction

  // Exponent bit that stage k's decision drives (stage 0 is the MSB).
  function automatic int stage_bit(input int exp_w, input int k);
    return exp_w - 1 - k;
  endfunction

endpackage

// File: rtl/int2fp_stage.sv
module int2fp_stage #(
  parameter int W     = 27,
  parameter int SH    = 8,
  parameter int EXP_W = 4,
  parameter int DBIT  = 3,
  parameter bit REG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_vld,
  input  logic [W-1:0]     i_word,
  input  logic [EXP_W-1:0] i_dec,
  output logic             o_vld,
  output logic [W-1:0]     o_word,
  output logic [EXP_W-1:0] o_dec
);

  logic             take;
  logic [W-1:0]     nxt_word;
  logic [EXP_W-1:0] nxt_dec;

  // Shift when the top SH bits hold no set bit.
  always_comb begin
    take     = ~|i_word[W-1 -: SH];
    nxt_word = take ? (i_word << SH) : i_word;
    nxt_dec  = i_dec | (EXP_W'(take) << DBIT);
  end

  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) o_vld <= 1'b0;
        else     o_vld <= i_vld;
      end
      always_ff @(posedge clk) begin
        o_word <= nxt_word;
        o_dec  <= nxt_dec;
      end
    end else begin : g_comb
      assign o_vld  = i_vld;
      assign o_word = nxt_word;
      assign o_dec  = nxt_dec;
    end
  endgenerate

endmodule

// File: rtl/int2fp_pack.sv
module int2fp_pack #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic [MANT_W-1:0]       top_bits,
  input  logic [EXP_W-1:0]        dec,
  output logic [EXP_W+MANT_W-1:0] word
);

  // A taken shift lowers the exponent, so the exponent is the inverted decision vector.
  assign word = {~dec, top_bits};

endmodule

// File: rtl/int2fp_norm.sv
module int2fp_norm #(
  parameter int MANT_W   = 12,
  parameter int EXP_W    = 4,
  parameter bit PIPELINE = 1'b1,
  localparam int IN_W    = MANT_W + (1 << EXP_W) - 1,
  localparam int OUT_W   = EXP_W + MANT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  import int2fp_pkg::*;

  logic             vld_s  [EXP_W+1];
  logic [IN_W-1:0]  word_s [EXP_W+1];
  logic [EXP_W-1:0] dec_s  [EXP_W+1];

  assign vld_s[0]  = in_valid;
  assign word_s[0] = in_data;
  assign dec_s[0]  = '0;

  for (genvar k = 0; k < EXP_W; k++) begin : g_stage
    int2fp_stage #(
      .W    (IN_W),
      .SH   (stage_shift(EXP_W, k)),
      .EXP_W(EXP_W),
      .DBIT (stage_bit(EXP_W, k)),
      .REG  (PIPELINE)
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .i_vld (vld_s[k]),
      .i_word(word_s[k]),
      .i_dec (dec_s[k]),
      .o_vld (vld_s[k+1]),
      .o_word(word_s[k+1]),
      .o_dec (dec_s[k+1])
    );
  end

  int2fp_pack #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_pack (
    .top_bits(word_s[EXP_W][IN_W-1 -: MANT_W]),
    .dec     (dec_s[EXP_W]),
    .word    (out_data)
  );

  assign out_valid = vld_s[EXP_W];

endmodule

// File: rtl/int2fp_norm_chk.sv
module int2fp_norm_chk #(
  parameter int MANT_W   = 12,
  parameter int EXP_W    = 4,
  parameter bit PIPELINE = 1'b1,
  localparam int IN_W    = MANT_W + (1 << EXP_W) - 1,
  localparam int OUT_W   = EXP_W + MANT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  logic            ref_v;
  logic [IN_W-1:0] ref_d;
  logic [EXP_W-1:0]  e;
  logic [MANT_W-1:0] m;

  assign e = out_data[OUT_W-1 -: EXP_W];
  assign m = out_data[MANT_W-1:0];

  generate
    if (PIPELINE) begin : g_shadow
      logic            sv [EXP_W];
      logic [IN_W-1:0] sd [EXP_W];
      always_ff @(posedge clk) begin
        for (int i = 0; i < EXP_W; i++) begin
          if (rst) sv[i] <= 1'b0;
          else     sv[i] <= (i == 0) ? in_valid : sv[i-1];
          sd[i] <= (i == 0) ? in_data : sd[i-1];
        end
      end
      assign ref_v = sv[EXP_W-1];
      assign ref_d = sd[EXP_W-1];

      p_flush_r7: assert property (@(posedge clk) rst |=> !out_valid);
    end else begin : g_direct
      assign ref_v = in_valid;
      assign ref_d = in_data;
    end
  endgenerate

  // R5 / R6 / R8: valid timing follows the accepted inputs
  p_lockstep_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid == ref_v);

  p_msb_set_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && e != '0) |-> m[MANT_W-1]);

  p_window_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && e != '0) |->
      (m == MANT_W'(ref_d >> e)) && ((ref_d >> (int'(e) + MANT_W)) == '0));

  p_small_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && e == '0) |->
      ((ref_d >> MANT_W) == '0) && (m == ref_d[MANT_W-1:0]));

endmodule

bind int2fp_norm int2fp_norm_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .PIPELINE(PIPELINE)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/int2fp_norm_tb.sv
module int2fp_norm_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [26:0] in_data = '0;
  logic        pv, cv;
  logic [15:0] pd, cd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  int2fp_norm #(.PIPELINE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(pv), .out_data(pd));

  int2fp_norm #(.PIPELINE(1'b0)) dut_c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(cv), .out_data(cd));

  // Reference: scan for the highest set bit.
  function automatic logic [15:0] ref_fp(input logic [26:0] x);
    int p = -1;
    int e;
    for (int i = 0; i < 27; i++) if (x[i]) p = i;
    e = (p < 12) ? 0 : p - 11;
    return {4'(e), 12'(x >> e)};
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    if (w[15:12] == 4'd0)  return "R1/R2";
    if (w[15:12] == 4'd15) return "R1/R4";
    return "R1/R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Four-slot model of the pipelined build
  logic        mv [4];
  logic [15:0] md [4];
  always @(posedge clk) begin
    for (int i = 3; i > 0; i--) begin
      mv[i] <= rst ? 1'b0 : mv[i-1];
      md[i] <= md[i-1];
    end
    mv[0] <= rst ? 1'b0 : in_valid;
    md[0] <= ref_fp(in_data);
  end

  // Compare both builds on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(pv === mv[3], "R5", {31'd0, pv}, {31'd0, mv[3]});
      if (mv[3]) chk(pd === md[3], tag_of(md[3]), {16'd0, pd}, {16'd0, md[3]});
      chk(cv === in_valid, "R6", {31'd0, cv}, {31'd0, in_valid});
      if (in_valid) begin
        chk(cd === ref_fp(in_data), "R6", {16'd0, cd}, {16'd0, ref_fp(in_data)});
        chk(cd === ref_fp(in_data), tag_of(ref_fp(in_data)), {16'd0, cd}, {16'd0, ref_fp(in_data)});
      end
    end
  end

  task automatic put(input bit v, input logic [26:0] d);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pv == 1'b0, "R7", {31'd0, pv}, 32'd0);

    // Directed corners: zero, exact range top, first inexact values, full scale
    put(1, 27'd0);
    put(1, 27'd1);
    put(1, 27'd4095);
    put(1, 27'd4096);
    put(1, 27'd4097);
    put(1, 27'd8191);
    put(1, 27'd8192);
    put(1, 27'h4000000);
    put(1, 27'h7FFFFFF);
    put(1, 27'h4000FFF);
    // R3: walk a single set bit, then the same with trailing ones
    for (int b = 0; b < 27; b++) put(1, 27'(1) << b);
    for (int b = 0; b < 27; b++) put(1, (27'(1) << b) | ((27'(1) << b) - 27'd1));
    // R8: gaps of varied length between inputs
    for (int g = 0; g < 6; g++) begin
      put(1, 27'(32'h00ABCDE << g));
      repeat (g) put(0, 27'h5555555);
    end
    put(0, '0);
    @(negedge clk);
    chk(cv == 1'b0, "R8", {31'd0, cv}, 32'd0);
    repeat (4) put(0, '0);
    @(negedge clk);
    chk(pv == 1'b0, "R8", {31'd0, pv}, 32'd0);
    // Random widths, mostly back-to-back
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      int w = int'($urandom_range(27, 1));
      put(($urandom_range(3, 0) != 0), 27'(r) & ((27'(1) << w) - 27'd1) | (27'(1) << (w - 1)));
    end
    // R7: reset with inputs in flight and a fresh input presented
    put(1, 27'h1234567);
    put(1, 27'h0000ABC);
    put(1, 27'h7000000);
    @(posedge clk); #1 rst = 1'b1; in_valid = 1'b1; in_data = 27'h0FFFFFF;
    @(posedge clk); #1 rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(pv == 1'b0, "R7", {31'd0, pv}, 32'd0);
    end
    put(1, 27'h0100000);
    repeat (6) put(0, '0);
    summary();
  end

endmodule